// File: doc/BRIEF.md
# Overlay-Window Command Sequencer

This block is the host-side engine that sends a single command to a phase-change non-volatile memory. The memory exposes its command interface as a small window of 16-bit registers on an ordinary word-write/word-read bus. A client hands over one request: a 16-bit command code, a 32-bit data word, a 32-bit target address, a 32-bit multi-purpose value (a count or a second address), and, for buffered commands, a payload that the block fetches entry by entry through an index port. The sequencer then produces every bus access the command needs and reports back once the device signals completion or a poll limit runs out.

A command has four phases. First the block writes the six command registers. For buffered commands it then reads a buffer-pointer register and streams the payload to consecutive addresses at the window base plus that pointer. Next it writes the execute register. Last it reads the status register repeatedly until the ready bit is set. A pair-mode input selects a 32-bit bus made of two stacked 16-bit devices. In that mode every register access is repeated two bytes higher for the second device, and both devices must report ready.

Top module: `ow_cmd_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. From the next cycle, `busy` is high and `req_ready` low, and both stay so up to and including the `done` cycle. No bus access occurs while idle.
- R2: With `pair_mode` low, the first six bus writes go to byte address `win_base + 2*off`, using these offsets in this order: 0x40 (code), 0x42 (data bits 15:0), 0x44 (address bits 15:0), 0x45 (address bits 31:16), 0x48 (multi-purpose bits 15:0), 0x49 (multi-purpose bits 31:16). A read and a write never occur in the same cycle.
- R3: With `pair_mode` high, the stride is 4 bytes per word offset. The six writes of R2 are followed by six more at the same addresses plus 2, in the same order. These carry the same values, except that the data register gets data bits 31:16.
- R4: For codes 0x00E9 and 0x00EA only, after the register writes the block makes one read at `win_base + stride*0x08`. It then writes N entries, where N is the multi-purpose value's bits [PCW-1:0]. Entry i goes to `win_base + pointer + i` and carries `pay_data` while `pay_idx` equals i. Any other code (such as 0x61, 0x62, 0x41, 0x42, 0x20) makes no pointer read and no payload writes.
- R5: After the register writes and any payload, the block writes 0x0001 to `win_base + stride*0x60`. In pair mode the same write follows at that address plus 2. Nothing is written after that.
- R6: Status is read at `win_base + stride*0x66`, and in pair mode also at that address plus 2 right after. The command completes when bit 7 is set: mask 0x0080 in single mode, or 0x00800080 on the pair with the second device in the upper half. No other status bit has any effect. A successful finish gives `done` with `fail` low.
- R7: If the status poll numbered `tmo_limit` (counting from 0) still shows not-ready, the block stops polling after exactly `tmo_limit`+1 polls and finishes with `done` and `fail` both high.
- R8: `done` is a one-cycle pulse. `fail` is meaningful only with `done` and is low otherwise. In the cycle after `done`, the block is idle again.
- R9: After reset, the block is idle: `req_ready`=1, and `busy`, `done`, `fail`, `mem_wr` and `mem_rd` are all 0.
- R10: A buffered code whose multi-purpose bits [PCW-1:0] are zero still makes the pointer read, but no payload writes. The execute write follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | 1 = two stacked x16 devices on a 32-bit bus; sampled at acceptance |
| win_base | input | AW | Window base byte address; sampled at acceptance |
| tmo_limit | input | TW | Index of the last status poll allowed; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_code | input | 16 | Command code |
| req_data | input | 32 | Command data |
| req_addr | input | 32 | Command target address |
| req_mpr | input | 32 | Multi-purpose value (count or address) |
| pay_idx | output | PCW | Index of the payload entry wanted |
| pay_data | input | 16 | Payload entry selected by `pay_idx` |
| mem_wr | output | 1 | Bus write strobe |
| mem_rd | output | 1 | Bus read strobe; data returns the next cycle |
| mem_addr | output | AW | Bus byte address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With `done`: poll limit expired |

## Verification
The bench sweeps every command code in both bus modes against a device model whose two halves go ready after chosen poll counts. One of those cases has the upper device late enough to exhaust the limit. A design that checks only the lower half, or that fails to merge the two halves under the paired mask, would report success there instead of failure. Payload lengths of zero, one and several probe the fill loop. An off-by-one in the count would add or drop a write, and zero would either skip the pointer read or wrap around into 256 writes. The bench also compares every logged write address and value in order, which catches a misplaced upper-data half, a wrong stride, a second-device pass placed between the first-device writes, and an extra or early execute. It counts polls at the limit boundary, so a design that stops one poll early or late is caught.

// File: rtl/ow_seq_pkg.sv
package ow_seq_pkg;

  // Word offsets inside the register window
  localparam logic [7:0] OFS_CODE = 8'h40;
  localparam logic [7:0] OFS_DATA = 8'h42;
  localparam logic [7:0] OFS_ADRL = 8'h44;
  localparam logic [7:0] OFS_ADRH = 8'h45;
  localparam logic [7:0] OFS_MPRL = 8'h48;
  localparam logic [7:0] OFS_MPRH = 8'h49;
  localparam logic [7:0] OFS_EXEC = 8'h60;
  localparam logic [7:0] OFS_STAT = 8'h66;
  localparam logic [7:0] OFS_BUFP = 8'h08;

  localparam logic [15:0] CODE_BUF_PROG = 16'h00E9;
  localparam logic [15:0] CODE_BUF_OVWR = 16'h00EA;
  localparam logic [15:0] EXEC_GO       = 16'h0001;

  localparam logic [31:0] RDY_MASK_ONE  = 32'h0000_0080;
  localparam logic [31:0] RDY_MASK_PAIR = 32'h0080_0080;

  typedef enum logic [3:0] {
    S_IDLE, S_REG, S_PTR, S_PTRW, S_FILL, S_EXEC, S_ST0, S_ST1, S_ST2, S_DONE
  } seq_state_t;

  function automatic logic is_buffered(input logic [15:0] code);
    return (code == CODE_BUF_PROG) || (code == CODE_BUF_OVWR);
  endfunction

  function automatic logic status_ready(input logic [31:0] sr, input logic pair);
    logic [31:0] m;
    m = pair ? RDY_MASK_PAIR : RDY_MASK_ONE;
    return (sr & m) == m;
  endfunction

endpackage

// File: rtl/ow_reg_script.sv
module ow_reg_script
  import ow_seq_pkg::*;
(
  input  logic [2:0]  step,
  input  logic        upper,
  input  logic [15:0] code,
  input  logic [31:0] data,
  input  logic [31:0] addr,
  input  logic [31:0] mpr,
  output logic [7:0]  offset,
  output logic [15:0] value
);

  always_comb begin
    case (step)
      3'd0: begin offset = OFS_CODE; value = code; end
      3'd1: begin offset = OFS_DATA; value = upper ? data[31:16] : data[15:0]; end
      3'd2: begin offset = OFS_ADRL; value = addr[15:0]; end
      3'd3: begin offset = OFS_ADRH; value = addr[31:16]; end
      3'd4: begin offset = OFS_MPRL; value = mpr[15:0]; end
      3'd5: begin offset = OFS_MPRH; value = mpr[31:16]; end
      default: begin offset = 8'h00; value = 16'h0000; end
    endcase
  end

endmodule

// File: rtl/ow_poll_timer.sv
module ow_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [TW-1:0] limit,
  output logic          at_limit
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + TW'(1);
  end

  assign at_limit = (cnt_q == limit);

endmodule

// File: rtl/ow_cmd_seq.sv
module ow_cmd_seq
  import ow_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int TW  = 16,
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pair_mode,
  input  logic [AW-1:0]  win_base,
  input  logic [TW-1:0]  tmo_limit,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [15:0]    req_code,
  input  logic [31:0]    req_data,
  input  logic [31:0]    req_addr,
  input  logic [31:0]    req_mpr,
  output logic [PCW-1:0] pay_idx,
  input  logic [15:0]    pay_data,
  output logic           mem_wr,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  output logic           busy,
  output logic           done,
  output logic           fail
);

  localparam logic [2:0] STEP_LAST = 3'd5;

  seq_state_t     state_q;
  logic [15:0]    code_q;
  logic [31:0]    data_q, addr_q, mpr_q;
  logic [AW-1:0]  base_q;
  logic [TW-1:0]  lim_q;
  logic           pair_q;
  logic [2:0]     step_q;
  logic           upper_q;
  logic [15:0]    ptr_q;
  logic [PCW-1:0] cnt_q;
  logic [15:0]    lo_q;
  logic           fail_q;

  logic [7:0]     scr_off;
  logic [15:0]    scr_val;
  logic [PCW-1:0] fill_cnt;
  logic           fill_last;
  logic [31:0]    sr_word;
  logic           tmr_at_limit;

  // Named internal events, used by the bound checker
  logic ev_accept, ev_eval, ev_ready, ev_tmo;

  function automatic logic [AW-1:0] ow_addr(input logic [AW-1:0] b, input logic [7:0] off,
                                            input logic pair, input logic up);
    logic [AW-1:0] o;
    o = AW'(off);
    return b + (pair ? (o << 2) : (o << 1)) + (up ? AW'(2) : AW'(0));
  endfunction

  ow_reg_script u_script (
    .step   (step_q),
    .upper  (upper_q),
    .code   (code_q),
    .data   (data_q),
    .addr   (addr_q),
    .mpr    (mpr_q),
    .offset (scr_off),
    .value  (scr_val)
  );

  assign fill_cnt  = mpr_q[PCW-1:0];
  assign fill_last = (cnt_q == fill_cnt - PCW'(1));

  assign ev_accept = req_valid && req_ready;
  assign ev_eval   = ((state_q == S_ST1) && !pair_q) || (state_q == S_ST2);
  assign sr_word   = (state_q == S_ST2) ? {mem_rdata, lo_q} : {16'h0000, mem_rdata};
  assign ev_ready  = ev_eval && status_ready(sr_word, pair_q);
  assign ev_tmo    = ev_eval && !ev_ready && tmr_at_limit;

  ow_poll_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_accept),
    .inc      (ev_eval && !ev_ready && !tmr_at_limit),
    .limit    (lim_q),
    .at_limit (tmr_at_limit)
  );

  // Bus drive, one access per cycle
  always_comb begin
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 16'h0000;
    case (state_q)
      S_REG: begin
        mem_wr    = 1'b1;
        mem_addr  = ow_addr(base_q, scr_off, pair_q, upper_q);
        mem_wdata = scr_val;
      end
      S_PTR: begin
        mem_rd   = 1'b1;
        mem_addr = ow_addr(base_q, OFS_BUFP, pair_q, 1'b0);
      end
      S_FILL: begin
        mem_wr    = 1'b1;
        mem_addr  = base_q + AW'(ptr_q) + AW'(cnt_q);
        mem_wdata = pay_data;
      end
      S_EXEC: begin
        mem_wr    = 1'b1;
        mem_addr  = ow_addr(base_q, OFS_EXEC, pair_q, upper_q);
        mem_wdata = EXEC_GO;
      end
      S_ST0: begin
        mem_rd   = 1'b1;
        mem_addr = ow_addr(base_q, OFS_STAT, pair_q, 1'b0);
      end
      S_ST1: begin
        if (pair_q) begin
          mem_rd   = 1'b1;
          mem_addr = ow_addr(base_q, OFS_STAT, pair_q, 1'b1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      code_q  <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      mpr_q   <= '0;
      base_q  <= '0;
      lim_q   <= '0;
      pair_q  <= 1'b0;
      step_q  <= '0;
      upper_q <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      lo_q    <= '0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (ev_accept) begin
            code_q  <= req_code;
            data_q  <= req_data;
            addr_q  <= req_addr;
            mpr_q   <= req_mpr;
            base_q  <= win_base;
            lim_q   <= tmo_limit;
            pair_q  <= pair_mode;
            step_q  <= '0;
            upper_q <= 1'b0;
            fail_q  <= 1'b0;
            state_q <= S_REG;
          end
        end
        S_REG: begin
          if (step_q == STEP_LAST) begin
            step_q <= '0;
            if (pair_q && !upper_q) begin
              upper_q <= 1'b1;
            end else begin
              upper_q <= 1'b0;
              state_q <= is_buffered(code_q) ? S_PTR : S_EXEC;
            end
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        S_PTR: state_q <= S_PTRW;
        S_PTRW: begin
          ptr_q   <= mem_rdata;
          cnt_q   <= '0;
          state_q <= (fill_cnt == '0) ? S_EXEC : S_FILL;
        end
        S_FILL: begin
          cnt_q <= cnt_q + PCW'(1);
          if (fill_last) state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (pair_q && !upper_q) begin
            upper_q <= 1'b1;
          end else begin
            upper_q <= 1'b0;
            state_q <= S_ST0;
          end
        end
        S_ST0: state_q <= S_ST1;
        S_ST1, S_ST2: begin
          if (state_q == S_ST1) lo_q <= mem_rdata;
          if ((state_q == S_ST1) && pair_q) begin
            state_q <= S_ST2;
          end else if (ev_ready) begin
            state_q <= S_DONE;
          end else if (ev_tmo) begin
            fail_q  <= 1'b1;
            state_q <= S_DONE;
          end else begin
            state_q <= S_ST0;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pay_idx   = cnt_q;
  assign req_ready = (state_q == S_IDLE);
  assign busy      = !req_ready;
  assign done      = (state_q == S_DONE);
  assign fail      = done && fail_q;

endmodule

// File: rtl/ow_seq_chk.sv
module ow_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic fail,
  input logic mem_wr,
  input logic mem_rd,
  input logic ev_accept,
  input logic ev_eval,
  input logic ev_ready,
  input logic ev_tmo
);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_wr || mem_rd));

  p_single_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  p_ready_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> (done && !fail));

  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ev_eval));

  p_timeout_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> (done && fail));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_fail_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

endmodule

bind ow_cmd_seq ow_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd),
  .ev_accept (ev_accept),
  .ev_eval   (ev_eval),
  .ev_ready  (ev_ready),
  .ev_tmo    (ev_tmo)
);

// File: tb/ow_cmd_seq_test.sv
module ow_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_mode = 1'b0;
  logic [31:0] win_base = '0;
  logic [15:0] tmo_limit = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_code = '0;
  logic [31:0] req_data = '0, req_addr = '0, req_mpr = '0;
  logic [7:0]  pay_idx;
  logic [15:0] pay_data;
  logic        mem_wr, mem_rd;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        busy, done, fail;

  always #10 clk = ~clk;

  ow_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .win_base(win_base),
    .tmo_limit(tmo_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_data(req_data), .req_addr(req_addr), .req_mpr(req_mpr),
    .pay_idx(pay_idx), .pay_data(pay_data), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail)
  );

  int nchk = 0;
  int nerr = 0;

  // payload source
  logic [15:0] seed = 16'h0000;
  assign pay_data = {8'hA5 ^ pay_idx, pay_idx} ^ seed;

  // device model
  logic [31:0] a_ptr, a_stlo, a_sthi;
  logic [15:0] ptr_val;
  int rl, rh;
  int lo_reads, hi_reads, ptr_reads, ptr_pos, n_act;
  logic [31:0] act_addr [64];
  logic [15:0] act_data [64];
  logic [15:0] rd_q = 16'h0000;
  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (mem_wr) begin
      if (n_act < 64) begin
        act_addr[n_act] = mem_addr;
        act_data[n_act] = mem_wdata;
      end
      n_act = n_act + 1;
    end
    if (mem_rd) begin
      if (mem_addr == a_ptr) begin
        ptr_reads = ptr_reads + 1;
        ptr_pos = n_act;
        rd_q <= ptr_val;
      end else if (mem_addr == a_stlo) begin
        rd_q <= (lo_reads >= rl) ? 16'h0081 : 16'hFF7F;
        lo_reads = lo_reads + 1;
      end else if (mem_addr == a_sthi) begin
        rd_q <= (hi_reads >= rh) ? 16'h8080 : 16'h7F7F;
        hi_reads = hi_reads + 1;
      end else begin
        rd_q <= 16'hDEAD;
      end
    end
  end

  // expected write list
  logic [31:0] exp_addr [64];
  logic [15:0] exp_data [64];
  string       exp_tag  [64];
  int          n_exp;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] offs(input int k);
    case (k)
      0: return 8'h40;
      1: return 8'h42;
      2: return 8'h44;
      3: return 8'h45;
      4: return 8'h48;
      default: return 8'h49;
    endcase
  endfunction

  task automatic push(input logic [31:0] a, input logic [15:0] d, input string t);
    exp_addr[n_exp] = a;
    exp_data[n_exp] = d;
    exp_tag[n_exp]  = t;
    n_exp++;
  endtask

  task automatic run_one(input int run, input bit wide, input logic [15:0] code, input int c);
    logic [31:0] stride, base;
    logic [15:0] v;
    bit buffered, exp_fail;
    int nfill, need, polls, lim, nregs, cyc;
    string rt;
    @(negedge clk);
    rt = wide ? "R3" : "R2";
    stride = wide ? 32'd4 : 32'd2;
    base = (wide ? 32'h0004_0000 : 32'h0000_8000) + 32'(run) * 32'h400;
    buffered = (code == 16'h00E9) || (code == 16'h00EA);
    case (c)
      0: begin rl = 0; rh = 0; lim = 3; nfill = 0; end
      1: begin rl = 1; rh = 4; lim = 6; nfill = 3; end
      2: begin rl = 9; rh = 2; lim = 3; nfill = 1; end
      default: begin rl = 0; rh = 7; lim = 2; nfill = 5; end
    endcase
    pair_mode = wide;
    win_base  = base;
    tmo_limit = 16'(lim);
    req_code  = code;
    req_data  = {16'hD000 | 16'(run), 16'h1000 | 16'(run)};
    req_addr  = {16'hA000 + 16'(run), 16'h0B00 + 16'(run)};
    req_mpr   = {16'h3C00 + 16'(c), 8'h00, 8'(nfill)};
    seed      = 16'(run * 3);
    ptr_val   = 16'h0200 + 16'(run * 8);
    a_ptr  = base + 32'h08 * stride;
    a_stlo = base + 32'h66 * stride;
    a_sthi = a_stlo + 32'd2;
    lo_reads = 0; hi_reads = 0; ptr_reads = 0; ptr_pos = -1; n_act = 0;
    // expected
    n_exp = 0;
    for (int p = 0; p < (wide ? 2 : 1); p++) begin
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: v = code;
          1: v = (p == 1) ? req_data[31:16] : req_data[15:0];
          2: v = req_addr[15:0];
          3: v = req_addr[31:16];
          4: v = req_mpr[15:0];
          default: v = req_mpr[31:16];
        endcase
        push(base + 32'(offs(k)) * stride + 32'(p * 2), v, rt);
      end
    end
    nregs = n_exp;
    if (buffered)
      for (int i = 0; i < nfill; i++)
        push(base + 32'(ptr_val) + 32'(i), {8'hA5 ^ 8'(i), 8'(i)} ^ seed, "R4");
    for (int p = 0; p < (wide ? 2 : 1); p++)
      push(base + 32'h60 * stride + 32'(p * 2), 16'h0001, "R5");
    need = (wide && rh > rl) ? rh : rl;
    exp_fail = need > lim;
    polls = exp_fail ? lim + 1 : need + 1;
    // issue
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R1", "busy/ready after accept", {busy, req_ready}, 2'b10);
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (!done && (fail || !busy)) check(0, "R8", "fail/busy before done", {busy, fail}, 2'b10);
    end
    check(done, "R8", "done reached", done, 1);
    check(busy, "R1", "busy in done cycle", busy, 1);
    check(fail == exp_fail, exp_fail ? "R7" : "R6", "fail flag", fail, exp_fail);
    check(n_act == n_exp, rt, "write count", n_act, n_exp);
    for (int i = 0; i < n_exp && i < n_act; i++) begin
      check(act_addr[i] == exp_addr[i], exp_tag[i], $sformatf("write %0d addr", i), act_addr[i], exp_addr[i]);
      check(act_data[i] == exp_data[i], exp_tag[i], $sformatf("write %0d data", i), act_data[i], exp_data[i]);
    end
    check(ptr_reads == (buffered ? 1 : 0), (buffered && nfill == 0) ? "R10" : "R4",
          "pointer reads", ptr_reads, buffered ? 1 : 0);
    if (buffered) check(ptr_pos == nregs, "R4", "pointer read position", ptr_pos, nregs);
    check(lo_reads == polls, exp_fail ? "R7" : "R6", "status polls", lo_reads, polls);
    check(hi_reads == (wide ? polls : 0), "R6", "upper status polls", hi_reads, wide ? polls : 0);
    @(negedge clk);
    check(!done && !busy && req_ready && !fail, "R8", "idle after done",
          {done, busy, req_ready, fail}, 4'b0010);
  endtask

  logic [15:0] codes [7];

  initial begin
    codes[0] = 16'h0061; codes[1] = 16'h0062; codes[2] = 16'h0041; codes[3] = 16'h0042;
    codes[4] = 16'h0020; codes[5] = 16'h00E9; codes[6] = 16'h00EA;
    a_ptr = '1; a_stlo = '1; a_sthi = '1; ptr_val = '0; rl = 0; rh = 0;
    lo_reads = 0; hi_reads = 0; ptr_reads = 0; ptr_pos = 0; n_act = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !busy && !done && !fail && !mem_wr && !mem_rd, "R9", "in reset",
          {req_ready, busy, done, fail, mem_wr, mem_rd}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !done && !fail && !mem_wr && !mem_rd, "R9", "after reset",
          {req_ready, busy, done, fail, mem_wr, mem_rd}, 6'b100000);
    begin
      int run;
      run = 0;
      for (int w = 0; w < 2; w++)
        for (int ci = 0; ci < 7; ci++)
          for (int c = 0; c < 4; c++) begin
            run_one(run, w[0], codes[ci], c);
            run++;
          end
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule